// File: doc/BRIEF.md
# Super I/O Configuration Unlock Front End

This block is the configuration front end of a legacy Super I/O device on an 8-bit host I/O bus. The bus has two ports: an index port at a base address, and a data port one address above it. After reset the configuration space is closed. The host opens it by writing a four-byte key to the index port. The last byte of that key depends on which of the two supported base addresses the instance decodes.

While configuration is open, the host writes an index to the index port and then reads or writes the selected register through the data port. The registers are:
- identification and version bytes, which are read-only;
- a logical-device selector;
- a global flash-control register;
- a pair of bytes holding the relocatable serial-flash I/O base. This pair is visible only while the flash logical device is selected.

A fixed exit code written to the exit register closes the space again. The flash-control fields and the flash base are driven out as ports so that the flash bridge next to this block can use them.

Top module: `sio_cfg_unlock`

## Requirements
- R1: After reset the space is closed and both the index and the selected logical device are 0x00. `flash_ctl` is 0 and `flash_base` equals the parameter `FLASH_BASE_RST`.
- R2: The space opens in the cycle after four consecutive index-port writes of 0x87, 0x01, 0x55 and then a last byte. The last byte is 0x55 when `BASE_PORT` is 0x2E and 0xAA when it is 0x4E.
- R3: A key byte that does not match restarts the match. If that byte is 0x87, it counts as the first key byte of a new attempt.
- R4: While the space is closed, index-port writes other than key bytes and all data-port writes change no register, and every read returns 0xFF.
- R5: Writing 0x02 through the data port while the index is 0x02 closes the space in the next cycle. Any other value written there has no effect, and index 0x02 reads 0x00.
- R6: Index 0x20 reads the high byte of `CHIP_ID`, index 0x21 reads its low byte, and index 0x22 reads `CHIP_VER`. Writes to these three indices are ignored.
- R7: Index 0x07 is the logical-device selector. It is readable and writable.
- R8: Index 0x24 is the flash-control register. Bit 0 is suspend, bits 1 to 3 enable flash address segments, bit 4 allows host writes to flash, and bit 5 selects the flash chip-select pin. Bits 7:6 read as 0, and `flash_ctl` follows bits 5:0.
- R9: When the selected logical device equals `FLASH_LDN` (default 7), index 0x64 holds the high byte of `flash_base` and index 0x65 holds the low byte. Both are writable. With any other device selected, these two indices read 0x00 and writes to them are ignored.
- R10: While the space is open, an index-port write sets the index and an index-port read returns it. The index holds its value across close and reopen. Indices that are not listed read 0x00.
- R11: Accesses to addresses other than `BASE_PORT` and `BASE_PORT`+1 have no effect and read 0xFF. A read is valid combinationally while `io_rd` is high. With `io_rd` low, `io_rdata` is 0xFF.
- R12: When a data-port write and a data-port read occur in the same cycle, the read returns the register's value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_addr | input | ADDR_W | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data (combinational) |
| cfg_open | output | 1 | Configuration space is open |
| flash_ctl | output | 6 | Flash-control fields, bits 5:0 of index 0x24 |
| flash_base | output | ADDR_W | Serial-flash I/O base |

## Verification
A data-port register update and a data-port read can occur in the same cycle. The bench provokes this by asserting write and read together on the flash-base low byte and on the logical-device selector. It expects the old value on `io_rdata` and the new value one cycle later. The same overlap on the exit register must return 0x00 while the space closes. A per-cycle behavioural model judges every one of these cycles.

// File: rtl/sio_cfg_pkg.sv
// Package: register indices, codes and key bytes for the configuration front end.
// Assumes an 8-bit data bus and a four-byte unlock key.
package sio_cfg_pkg;
    localparam int          KEY_LEN   = 4;
    localparam int          CTL_W     = 6;
    localparam logic [7:0]  IX_EXIT   = 8'h02;
    localparam logic [7:0]  IX_LDN    = 8'h07;
    localparam logic [7:0]  IX_ID_HI  = 8'h20;
    localparam logic [7:0]  IX_ID_LO  = 8'h21;
    localparam logic [7:0]  IX_VER    = 8'h22;
    localparam logic [7:0]  IX_FCTL   = 8'h24;
    localparam logic [7:0]  IX_FB_HI  = 8'h64;
    localparam logic [7:0]  IX_FB_LO  = 8'h65;
    localparam logic [7:0]  EXIT_CODE = 8'h02;
    localparam logic [7:0]  BUS_IDLE  = 8'hFF;

    // Key byte at position pos; the last byte depends on the decoded base port.
    function automatic logic [7:0] key_byte(input logic [15:0] base, input logic [1:0] pos);
        case (pos)
            2'd0:    key_byte = 8'h87;
            2'd1:    key_byte = 8'h01;
            2'd2:    key_byte = 8'h55;
            default: key_byte = (base == 16'h004E) ? 8'hAA : 8'h55;
        endcase
    endfunction
endpackage

// File: rtl/sio_key_match.sv
// Key matcher: tracks index-port writes while closed and opens the space on a full key.
// Assumes idx_wr is a single-cycle strobe per write; relock is honoured only while open.
module sio_key_match
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] BASE_PORT = 16'h002E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    input  logic       relock,
    output logic       open
);
    localparam int PW = $clog2(KEY_LEN);

    logic [PW-1:0] pos;
    logic [7:0]    want;
    logic          at_last;

    // Expected byte at the current match position
    assign want    = key_byte(BASE_PORT, 2'(pos));
    assign at_last = (pos == PW'(KEY_LEN - 1));

    // Match position and open flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            open <= 1'b0;
        end else if (open) begin
            if (relock) open <= 1'b0;
        end else if (idx_wr) begin
            if (wdata == want) begin
                if (at_last) begin
                    open <= 1'b1;
                    pos  <= '0;
                end else begin
                    pos <= pos + 1'b1;
                end
            end else begin
                pos <= (wdata == key_byte(BASE_PORT, 2'd0)) ? PW'(1) : '0;
            end
        end
    end
endmodule

// File: rtl/sio_cfg_regs.sv
// Register file: index latch, global registers and the logical-device-banked flash base.
// Assumes writes arrive only as strobes; rd_val is the combinational view of the indexed register.
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W         = 16,
    parameter logic [15:0] CHIP_ID        = 16'h8716,
    parameter logic [7:0]  CHIP_VER       = 8'h03,
    parameter logic [7:0]  FLASH_LDN      = 8'h07,
    parameter logic [ADDR_W-1:0] FLASH_BASE_RST = ADDR_W'(16'h0820)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open,
    input  logic              idx_wr,
    input  logic              dat_wr,
    input  logic [7:0]        wdata,
    output logic [7:0]        idx,
    output logic [7:0]        rd_val,
    output logic              relock,
    output logic [CTL_W-1:0]  flash_ctl,
    output logic [ADDR_W-1:0] flash_base
);
    localparam int HI_W = ADDR_W - 8;

    logic [7:0] ldn;
    logic       wr_en;
    logic       bank_hit;

    assign wr_en    = open && dat_wr;
    assign bank_hit = (ldn == FLASH_LDN);
    assign relock   = wr_en && (idx == IX_EXIT) && (wdata == EXIT_CODE);

    // Index latch, writable only while the space is open
    always_ff @(posedge clk) begin
        if (!rst_n)              idx <= '0;
        else if (open && idx_wr) idx <= wdata;
    end

    // Writable registers behind the data port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn        <= '0;
            flash_ctl  <= '0;
            flash_base <= FLASH_BASE_RST;
        end else if (wr_en) begin
            case (idx)
                IX_LDN:  ldn       <= wdata;
                IX_FCTL: flash_ctl <= wdata[CTL_W-1:0];
                IX_FB_HI: if (bank_hit) flash_base[ADDR_W-1:8] <= HI_W'(wdata);
                IX_FB_LO: if (bank_hit) flash_base[7:0]        <= wdata;
                default: ;
            endcase
        end
    end

    // Read view of the indexed register
    always_comb begin
        case (idx)
            IX_LDN:   rd_val = ldn;
            IX_ID_HI: rd_val = CHIP_ID[15:8];
            IX_ID_LO: rd_val = CHIP_ID[7:0];
            IX_VER:   rd_val = CHIP_VER;
            IX_FCTL:  rd_val = 8'(flash_ctl);
            IX_FB_HI: rd_val = bank_hit ? 8'(flash_base[ADDR_W-1:8]) : 8'h00;
            IX_FB_LO: rd_val = bank_hit ? flash_base[7:0] : 8'h00;
            default:  rd_val = 8'h00;
        endcase
    end
endmodule

// File: rtl/sio_cfg_unlock.sv
// Top: decodes the index/data port pair, gates access on the unlock key, drives read data.
// Assumes BASE_PORT is 0x2E or 0x4E and at most one access address per cycle.
module sio_cfg_unlock
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W         = 16,
    parameter logic [ADDR_W-1:0] BASE_PORT = ADDR_W'(16'h002E),
    parameter logic [15:0] CHIP_ID        = 16'h8716,
    parameter logic [7:0]  CHIP_VER       = 8'h03,
    parameter logic [7:0]  FLASH_LDN      = 8'h07,
    parameter logic [ADDR_W-1:0] FLASH_BASE_RST = ADDR_W'(16'h0820)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cfg_open,
    output logic [CTL_W-1:0]  flash_ctl,
    output logic [ADDR_W-1:0] flash_base
);
    localparam logic [ADDR_W-1:0] DATA_PORT = BASE_PORT + ADDR_W'(1);

    logic       hit_idx, hit_dat;
    logic [7:0] idx, rd_val;
    logic       relock;

    assign hit_idx = (io_addr == BASE_PORT);
    assign hit_dat = (io_addr == DATA_PORT);

    sio_key_match #(.BASE_PORT(16'(BASE_PORT))) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (io_wr && hit_idx),
        .wdata  (io_wdata),
        .relock (relock),
        .open   (cfg_open)
    );

    sio_cfg_regs #(
        .ADDR_W         (ADDR_W),
        .CHIP_ID        (CHIP_ID),
        .CHIP_VER       (CHIP_VER),
        .FLASH_LDN      (FLASH_LDN),
        .FLASH_BASE_RST (FLASH_BASE_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .open       (cfg_open),
        .idx_wr     (io_wr && hit_idx),
        .dat_wr     (io_wr && hit_dat),
        .wdata      (io_wdata),
        .idx        (idx),
        .rd_val     (rd_val),
        .relock     (relock),
        .flash_ctl  (flash_ctl),
        .flash_base (flash_base)
    );

    // Read data mux: idle value unless an open-space read hits the port pair
    always_comb begin
        if (!io_rd || !cfg_open) io_rdata = BUS_IDLE;
        else if (hit_idx)        io_rdata = idx;
        else if (hit_dat)        io_rdata = rd_val;
        else                     io_rdata = BUS_IDLE;
    end
endmodule

// File: rtl/sio_cfg_unlock_chk.sv
// Checker: port-level properties of the unlock front end, bound to every instance of the top.
// Assumes the synchronous active-low reset is held for at least one clock at start.
module sio_cfg_unlock_chk #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_PORT = ADDR_W'(16'h002E)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic              io_rd,
    input logic [ADDR_W-1:0] io_addr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              cfg_open,
    input logic [5:0]        flash_ctl,
    input logic [ADDR_W-1:0] flash_base
);
    localparam logic [ADDR_W-1:0] DATA_PORT = BASE_PORT + ADDR_W'(1);
    localparam logic [7:0] LAST_KEY = (BASE_PORT == ADDR_W'(16'h004E)) ? 8'hAA : 8'h55;

    AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(io_wr && io_addr == BASE_PORT && io_wdata == LAST_KEY)); // R2
    AST_CLOSE_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_open) |-> $past(io_wr && io_addr == DATA_PORT && io_wdata == 8'h02)); // R5
    AST_CLOSED_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd) |-> io_rdata == 8'hFF); // R4
    AST_CLOSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_open) |-> ($stable(flash_ctl) && $stable(flash_base))); // R4
    AST_BASE_WR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flash_base) |-> $past(cfg_open && io_wr && io_addr == DATA_PORT)); // R9
    AST_CTL_WR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flash_ctl) |-> $past(cfg_open && io_wr && io_addr == DATA_PORT)); // R8
endmodule

bind sio_cfg_unlock sio_cfg_unlock_chk #(.ADDR_W(ADDR_W), .BASE_PORT(BASE_PORT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .cfg_open   (cfg_open),
    .flash_ctl  (flash_ctl),
    .flash_base (flash_base)
);

// File: tb/sio_cfg_unlock_test.sv
// Bench: behavioural per-cycle model of the configuration space, compared every clock.
module sio_cfg_unlock_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata, alt_rdata;
    logic        cfg_open, alt_open;
    logic [5:0]  flash_ctl, alt_ctl;
    logic [15:0] flash_base, alt_base;

    always #4 clk = ~clk;

    sio_cfg_unlock uut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
        .flash_ctl(flash_ctl), .flash_base(flash_base));

    sio_cfg_unlock #(.BASE_PORT(16'h004E)) uut_alt (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(alt_rdata), .cfg_open(alt_open),
        .flash_ctl(alt_ctl), .flash_base(alt_base));

    int n_cmp = 0, n_bad = 0, cycles = 0;
    string cur_req = "R1";

    // Behavioural model state
    int m_open = 0, m_k = 0, m_idx = 0, m_ldn = 0, m_ctl = 0, m_base = 'h0820;
    int key[4] = '{'h87, 'h01, 'h55, 'h55};

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int reg_val(int ix);
        case (ix)
            'h07: return m_ldn;
            'h20: return 'h87;
            'h21: return 'h16;
            'h22: return 'h03;
            'h24: return m_ctl;
            'h64: return (m_ldn == 7) ? (m_base >> 8) : 0;
            'h65: return (m_ldn == 7) ? (m_base & 'hFF) : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_rd(bit rd, int a);
        if (!rd || m_open == 0) return 'hFF;
        if (a == 'h2E) return m_idx;
        if (a == 'h2F) return reg_val(m_idx);
        return 'hFF;
    endfunction

    task automatic model_step(bit wr, int a, int d);
        if (!wr) return;
        if (a == 'h2E) begin
            if (m_open != 0) m_idx = d;
            else if (d == key[m_k]) begin
                m_k++;
                if (m_k == 4) begin m_open = 1; m_k = 0; end
            end else m_k = (d == 'h87) ? 1 : 0;
        end else if (a == 'h2F && m_open != 0) begin
            case (m_idx)
                'h02: if (d == 2) m_open = 0;
                'h07: m_ldn = d;
                'h24: m_ctl = d & 'h3F;
                'h64: if (m_ldn == 7) m_base = (d << 8) | (m_base & 'hFF);
                'h65: if (m_ldn == 7) m_base = (m_base & 'hFF00) | d;
                default: ;
            endcase
        end
    endtask

    // One bus cycle: drive, compare against the model before the edge, then advance the model
    task automatic cyc(bit wr, bit rd, int a, int d);
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_addr = 16'(a); io_wdata = 8'(d);
        #1;
        check(cur_req, "rdata", int'(io_rdata), exp_rd(rd, a));
        check(cur_req, "open", int'(cfg_open), m_open);
        check(cur_req, "flash_ctl", int'(flash_ctl), m_ctl);
        check(cur_req, "flash_base", int'(flash_base), m_base);
        @(posedge clk);
        model_step(wr, a, d);
    endtask

    task automatic wr_ix(int d);  cyc(1, 0, 'h2E, d); endtask
    task automatic wr_dat(int d); cyc(1, 0, 'h2F, d); endtask
    task automatic rd_dat();      cyc(0, 1, 'h2F, 0); endtask
    task automatic rd_ix();       cyc(0, 1, 'h2E, 0); endtask
    task automatic idle();        cyc(0, 0, 0, 0); endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1"; idle(); rd_dat(); rd_ix();
        // R4: closed space ignores index/data writes and reads 0xFF
        cur_req = "R4"; wr_ix('h24); wr_dat('h3F); rd_dat(); rd_ix(); idle();
        // R3: broken key does not open; mismatching 0x87 restarts as first byte
        cur_req = "R3"; wr_ix('h87); wr_ix('h01); wr_ix('h00); wr_ix('h55); wr_ix('h55); idle();
        wr_ix('h87); wr_ix('h01); wr_ix('h87); wr_ix('h01); wr_ix('h55);
        // R2: final key byte opens on the next cycle
        cur_req = "R2"; wr_ix('h55); idle(); idle();
        // R10: index held from before (closed writes ignored), unlisted index reads 0
        cur_req = "R10"; rd_ix(); wr_ix('h30); rd_ix(); rd_dat();
        // R6: identification and version, read-only
        cur_req = "R6"; wr_ix('h20); rd_dat(); wr_dat('h11); rd_dat();
        wr_ix('h21); rd_dat(); wr_ix('h22); rd_dat();
        // R7: logical-device selector
        cur_req = "R7"; wr_ix('h07); wr_dat('h03); rd_dat();
        // R9: flash base banked on logical device 7
        cur_req = "R9"; wr_ix('h64); wr_dat('hAB); rd_dat();
        wr_ix('h07); wr_dat('h07); wr_ix('h64); wr_dat('h0A); rd_dat();
        wr_ix('h65); wr_dat('h48); rd_dat(); idle();
        // R12: same-cycle write and read return the old value
        cur_req = "R12"; cyc(1, 1, 'h2F, 'hC8); rd_dat();
        wr_ix('h07); cyc(1, 1, 'h2F, 'h05); rd_dat(); wr_ix('h64); rd_dat();
        wr_ix('h07); wr_dat('h07);
        // R8: flash-control fields, upper bits read zero
        cur_req = "R8"; wr_ix('h24); wr_dat('hFF); rd_dat(); wr_dat('h12); rd_dat(); wr_dat('h21); rd_dat();
        // R11: other addresses ignored
        cur_req = "R11"; cyc(1, 0, 'h30, 'h77); cyc(0, 1, 'h30, 0); rd_ix(); rd_dat(); cyc(0, 1, 'h2F, 0);
        cyc(0, 0, 'h2F, 0);
        // R5: wrong exit code ignored, correct one closes
        cur_req = "R5"; wr_ix('h02); rd_dat(); wr_dat('h01); idle(); cyc(1, 1, 'h2F, 'h02); idle(); rd_dat();
        // R4: after close, data writes leave registers alone
        cur_req = "R4"; wr_dat('h00); wr_ix('h24); wr_dat('h00); idle();
        // R10: reopen, index kept across close
        cur_req = "R10"; wr_ix('h87); wr_ix('h01); wr_ix('h55); wr_ix('h55); rd_ix(); rd_dat();
        // R2: alternate base uses 0xAA as last byte; main instance ignores that address
        cur_req = "R2";
        cyc(1, 0, 'h4E, 'h87); cyc(1, 0, 'h4E, 'h01); cyc(1, 0, 'h4E, 'h55); cyc(1, 0, 'h4E, 'h55);
        idle(); check("R2", "alt open after 0x55 tail", int'(alt_open), 0);
        cyc(1, 0, 'h4E, 'h87); cyc(1, 0, 'h4E, 'h01); cyc(1, 0, 'h4E, 'h55); cyc(1, 0, 'h4E, 'hAA);
        idle(); check("R2", "alt open after 0xAA tail", int'(alt_open), 1);
        cyc(0, 1, 'h4F, 0); idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule